// File: doc/BRIEF.md
# Device/Function Handler Slot Allocator

This block gives each device/function code a handler slot, up to a fixed capacity. The code is eight bits wide: its upper five bits name the device and its lower three bits name the function. A client registers a code with a valid/ready handshake. The block checks a 256-entry map. If the code has no slot yet and a slot is still free, the block assigns the next slot. Slots are given out strictly in the order requests arrive, starting at zero.

One cycle after a request is accepted, a single-cycle response appears. It shows whether the request was granted, refused as a duplicate, or refused because every slot is taken. The response also carries the slot index and the device and function fields of the code. A separate combinational port returns the slot for any code. A code with no slot reads back an unassigned marker, whose value equals the slot capacity. The number of slots in use is always visible on `used_count`.

Top module: `dfslot_table`

## Requirements
- R1: Synchronous active-high reset sets `used_count` to 0 and sets every one of the 256 entries to unassigned. An unassigned lookup returns `lkp_hit`=0 and `lkp_slot`=NUM_SLOTS (16 by default). `reg_ready` is 0 while reset is held.
- R2: A granted registration gets the value `used_count` had before the request, so successive grants receive 0, 1, 2 and so on in arrival order. `used_count` then goes up by one.
- R3: A registration for a code that already has a slot is refused with `rsp_dup`=1 and `rsp_ok`=0. `rsp_slot` carries the slot the code already holds, and neither the map nor `used_count` changes.
- R4: When `used_count` equals NUM_SLOTS, a registration for an unmapped code is refused with `rsp_full`=1. `rsp_slot` then equals NUM_SLOTS, and the code stays unassigned.
- R5: A request accepted on a clock edge (`reg_valid` and `reg_ready` both 1) produces `rsp_valid`=1 for exactly the following cycle. Cycles with no accepted request produce no response. Exactly one of `rsp_ok`, `rsp_dup`, `rsp_full` is set.
- R6: A lookup is combinational. From the cycle after a grant, `lkp_slot` for that code returns the assigned slot with `lkp_hit`=1.
- R7: `rsp_dev` equals bits 7:3 of the registered code and `rsp_fn` equals bits 2:0.
- R8: A reset asserted mid-operation frees every slot. After it, a previously mapped code reads unassigned and the next grant receives slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Registration request present |
| reg_ready | output | 1 | Block accepts a request this cycle |
| reg_code | input | 8 | Device/function code to register |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_ok | output | 1 | Request granted |
| rsp_dup | output | 1 | Refused: code already mapped |
| rsp_full | output | 1 | Refused: no free slot |
| rsp_slot | output | SLOT_W (5) | Granted or existing slot, or NUM_SLOTS when full |
| rsp_dev | output | 5 | Device field of the code |
| rsp_fn | output | 3 | Function field of the code |
| lkp_code | input | 8 | Code to look up |
| lkp_hit | output | 1 | Code has a slot |
| lkp_slot | output | SLOT_W (5) | Slot of the code, or NUM_SLOTS if unassigned |
| used_count | output | SLOT_W (5) | Number of slots handed out |

## Verification
The bench registers two copies of the same code back to back. A design that failed to see its own just-written entry would grant a second slot to that code. It fills every slot and then sends one more unmapped code. A counter that wrapped, or a full test that compared against capacity minus one, would then grant a bogus slot or refuse one request too early. A full 256-code lookup sweep after the fill catches any write that reaches the wrong entry. A reset given mid-operation confirms that stale mappings do not survive.

// File: rtl/dfslot_pkg.sv
package dfslot_pkg;

    localparam int CODE_W    = 8;
    localparam int FN_W      = 3;
    localparam int DEV_W     = CODE_W - FN_W;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DEV_W-1:0]  dev_t;
    typedef logic [FN_W-1:0]   fn_t;

    typedef enum logic [1:0] {
        VERDICT_GRANT = 2'd0,
        VERDICT_DUP   = 2'd1,
        VERDICT_FULL  = 2'd2
    } verdict_e;

    function automatic dev_t dev_of(input code_t c);
        return c[CODE_W-1:FN_W];
    endfunction

    function automatic fn_t fn_of(input code_t c);
        return c[FN_W-1:0];
    endfunction

endpackage

// File: rtl/dfslot_map.sv
module dfslot_map
    import dfslot_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  code_t             wr_code,
    input  logic [SLOT_W-1:0] wr_slot,
    input  code_t             rd_a_code,
    output logic [SLOT_W-1:0] rd_a_slot,
    input  code_t             rd_b_code,
    output logic [SLOT_W-1:0] rd_b_slot
);

    localparam logic [SLOT_W-1:0] UNASSIGNED = SLOT_W'(NUM_SLOTS);

    logic [SLOT_W-1:0] entry_q [NUM_CODES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CODES; i++) begin
                entry_q[i] <= UNASSIGNED;
            end
        end else if (wr_en) begin
            entry_q[wr_code] <= wr_slot;
        end
    end

    assign rd_a_slot = entry_q[rd_a_code];
    assign rd_b_slot = entry_q[rd_b_code];

endmodule

// File: rtl/dfslot_counter.sv
module dfslot_counter #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [SLOT_W-1:0] count,
    output logic              exhausted
);

    localparam logic [SLOT_W-1:0] LIMIT = SLOT_W'(NUM_SLOTS);

    logic [SLOT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (inc && (count_q != LIMIT)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count     = count_q;
    assign exhausted = (count_q == LIMIT);

endmodule

// File: rtl/dfslot_arbiter.sv
module dfslot_arbiter
    import dfslot_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              fire,
    input  logic [SLOT_W-1:0] held_slot,
    input  logic [SLOT_W-1:0] next_slot,
    input  logic              exhausted,
    output verdict_e          verdict,
    output logic [SLOT_W-1:0] out_slot,
    output logic              grant
);

    localparam logic [SLOT_W-1:0] UNASSIGNED = SLOT_W'(NUM_SLOTS);

    always_comb begin
        verdict  = VERDICT_GRANT;
        out_slot = next_slot;
        if (held_slot != UNASSIGNED) begin
            verdict  = VERDICT_DUP;
            out_slot = held_slot;
        end else if (exhausted) begin
            verdict  = VERDICT_FULL;
            out_slot = UNASSIGNED;
        end
        grant = fire && (verdict == VERDICT_GRANT);
    end

endmodule

// File: rtl/dfslot_table.sv
module dfslot_table
    import dfslot_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic [7:0]        reg_code,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_dup,
    output logic              rsp_full,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [4:0]        rsp_dev,
    output logic [2:0]        rsp_fn,
    input  logic [7:0]        lkp_code,
    output logic              lkp_hit,
    output logic [SLOT_W-1:0] lkp_slot,
    output logic [SLOT_W-1:0] used_count
);

    localparam logic [SLOT_W-1:0] UNASSIGNED = SLOT_W'(NUM_SLOTS);

    typedef struct packed {
        logic              valid;
        verdict_e          verdict;
        logic [SLOT_W-1:0] slot;
        code_t             code;
    } resp_t;

    logic              fire;
    logic              grant;
    logic              exhausted;
    logic [SLOT_W-1:0] held_slot;
    logic [SLOT_W-1:0] count;
    logic [SLOT_W-1:0] pick_slot;
    verdict_e          verdict;
    resp_t             resp_q;

    assign reg_ready = !rst;
    assign fire      = reg_valid && reg_ready;

    dfslot_map #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) map_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (grant),
        .wr_code   (reg_code),
        .wr_slot   (count),
        .rd_a_code (reg_code),
        .rd_a_slot (held_slot),
        .rd_b_code (lkp_code),
        .rd_b_slot (lkp_slot)
    );

    dfslot_counter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .inc       (grant),
        .count     (count),
        .exhausted (exhausted)
    );

    dfslot_arbiter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) arb_i (
        .fire      (fire),
        .held_slot (held_slot),
        .next_slot (count),
        .exhausted (exhausted),
        .verdict   (verdict),
        .out_slot  (pick_slot),
        .grant     (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '{valid: 1'b0, verdict: VERDICT_GRANT, slot: '0, code: '0};
        end else begin
            resp_q.valid <= fire;
            if (fire) begin
                resp_q.verdict <= verdict;
                resp_q.slot    <= pick_slot;
                resp_q.code    <= reg_code;
            end
        end
    end

    assign rsp_valid  = resp_q.valid;
    assign rsp_ok     = resp_q.valid && (resp_q.verdict == VERDICT_GRANT);
    assign rsp_dup    = resp_q.valid && (resp_q.verdict == VERDICT_DUP);
    assign rsp_full   = resp_q.valid && (resp_q.verdict == VERDICT_FULL);
    assign rsp_slot   = resp_q.slot;
    assign rsp_dev    = dev_of(resp_q.code);
    assign rsp_fn     = fn_of(resp_q.code);
    assign lkp_hit    = (lkp_slot != UNASSIGNED);
    assign used_count = count;

endmodule

// File: rtl/dfslot_table_chk.sv
module dfslot_table_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic              reg_ready,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_dup,
    input logic              rsp_full,
    input logic [SLOT_W-1:0] rsp_slot,
    input logic [SLOT_W-1:0] used_count
);

    // R2: a grant advances the count by one and returns the prior count
    p_grant_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (used_count == SLOT_W'($past(used_count) + 1'b1)))
        else $error("grant did not advance count");

    p_grant_order_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (rsp_slot == $past(used_count)))
        else $error("granted slot out of order");

    // R3: refusals leave the count untouched
    p_refuse_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> $stable(used_count))
        else $error("refusal changed count");

    // R4: count never passes capacity; a full refusal only at capacity
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        used_count <= SLOT_W'(NUM_SLOTS))
        else $error("count beyond capacity");

    p_full_at_cap_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_full |-> (used_count == SLOT_W'(NUM_SLOTS) && rsp_slot == SLOT_W'(NUM_SLOTS)))
        else $error("full refusal below capacity");

    // R5: one response per accepted request, one verdict flag
    p_resp_follows_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_ready) |=> rsp_valid)
        else $error("missing response");

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid && reg_ready) |=> !rsp_valid)
        else $error("spurious response");

    p_one_verdict_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_ok, rsp_dup, rsp_full}) == 1))
        else $error("verdict flags not exclusive");

endmodule

bind dfslot_table dfslot_table_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_valid  (reg_valid),
    .reg_ready  (reg_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_dup    (rsp_dup),
    .rsp_full   (rsp_full),
    .rsp_slot   (rsp_slot),
    .used_count (used_count)
);

// File: tb/dfslot_table_tb_top.sv
`timescale 1ns/1ps
module dfslot_table_tb_top;

    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
    localparam int MARK      = NUM_SLOTS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_valid = 1'b0;
    logic              reg_ready;
    logic [7:0]        reg_code = '0;
    logic              rsp_valid, rsp_ok, rsp_dup, rsp_full;
    logic [SLOT_W-1:0] rsp_slot;
    logic [4:0]        rsp_dev;
    logic [2:0]        rsp_fn;
    logic [7:0]        lkp_code = '0;
    logic              lkp_hit;
    logic [SLOT_W-1:0] lkp_slot;
    logic [SLOT_W-1:0] used_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int model_map [256];
    int model_cnt;

    always #2.5 clk = ~clk;

    dfslot_table #(.NUM_SLOTS(NUM_SLOTS)) dut_i (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_code(reg_code), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_dup(rsp_dup), .rsp_full(rsp_full), .rsp_slot(rsp_slot),
        .rsp_dev(rsp_dev), .rsp_fn(rsp_fn), .lkp_code(lkp_code),
        .lkp_hit(lkp_hit), .lkp_slot(lkp_slot), .used_count(used_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) model_map[i] = MARK;
        model_cnt = 0;
    endtask

    // one registration; response checked against the model at the next negedge
    task automatic do_reg(input logic [7:0] code, input string req);
        int exp_slot;
        int kind; // 0 grant, 1 dup, 2 full
        if (model_map[code] != MARK) begin
            kind = 1; exp_slot = model_map[code];
        end else if (model_cnt == NUM_SLOTS) begin
            kind = 2; exp_slot = MARK;
        end else begin
            kind = 0; exp_slot = model_cnt;
            model_map[code] = model_cnt;
            model_cnt++;
        end
        @(negedge clk);
        reg_valid = 1'b1;
        reg_code  = code;
        @(negedge clk);
        reg_valid = 1'b0;
        check(rsp_valid == 1'b1, {req, " rsp_valid R5"}, rsp_valid, 1);
        check(rsp_ok == (kind == 0) && rsp_dup == (kind == 1) && rsp_full == (kind == 2),
              {req, " verdict"}, {rsp_full, rsp_dup, rsp_ok}, (1 << kind));
        check(rsp_slot == exp_slot, {req, " slot"}, rsp_slot, exp_slot);
        check(used_count == model_cnt, {req, " count"}, used_count, model_cnt);
    endtask

    task automatic look(input logic [7:0] code, input string req);
        lkp_code = code;
        #0.5;
        check(lkp_slot == model_map[code] && lkp_hit == (model_map[code] != MARK),
              req, lkp_slot, model_map[code]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(reg_ready == 1'b0, "R1 ready low in reset", reg_ready, 0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check(used_count == 0, "R1 count after reset", used_count, 0);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        look(8'h00, "R1 lookup 0x00 unassigned");
        look(8'hFF, "R1 lookup 0xFF unassigned");
    endtask

    task automatic t_order();
        do_reg(8'h00, "R2 first");
        do_reg(8'h5B, "R2 second");
        do_reg(8'hC7, "R2 third");
        look(8'h5B, "R6 lookup after grant");
        look(8'h5C, "R6 neighbour unassigned");
    endtask

    task automatic t_fields();
        do_reg(8'hAD, "R7 fields");
        check(rsp_dev == 5'h15, "R7 dev", rsp_dev, 5'h15);
        check(rsp_fn == 3'h5, "R7 fn", rsp_fn, 3'h5);
    endtask

    task automatic t_dup();
        do_reg(8'h5B, "R3 dup of existing");
        // back to back, same code: second must see the first's entry
        @(negedge clk);
        reg_valid = 1'b1; reg_code = 8'h3E;
        @(negedge clk);
        check(rsp_ok == 1'b1 && rsp_slot == model_cnt, "R3 b2b first grant", rsp_slot, model_cnt);
        model_map[8'h3E] = model_cnt; model_cnt++;
        @(negedge clk);
        reg_valid = 1'b0;
        check(rsp_dup == 1'b1 && rsp_slot == model_map[8'h3E], "R3 b2b second dup",
              rsp_slot, model_map[8'h3E]);
        check(used_count == model_cnt, "R3 count unchanged", used_count, model_cnt);
        look(8'h3E, "R3 mapping kept");
    endtask

    task automatic t_idle();
        reg_code = 8'h77;
        repeat (3) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R5 no response when idle", rsp_valid, 0);
        end
        look(8'h77, "R5 idle code stays unassigned");
    endtask

    task automatic t_fill();
        int code = 8'h10;
        while (model_cnt < NUM_SLOTS) begin
            do_reg(8'(code), "R2 fill");
            code += 3;
        end
        do_reg(8'hE1, "R4 over capacity");
        look(8'hE1, "R4 refused code unassigned");
        do_reg(8'h00, "R3 dup when full");
        for (int c = 0; c < 256; c++) look(8'(c), "R6 sweep");
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check(used_count == 0, "R8 count cleared", used_count, 0);
        lkp_code = 8'h5B;
        #0.5;
        check(lkp_hit == 1'b0 && lkp_slot == MARK, "R8 stale mapping gone", lkp_slot, MARK);
        do_reg(8'hE1, "R8 restart at slot 0");
    endtask

    initial begin
        model_clear();
        t_reset();
        t_order();
        t_fields();
        t_dup();
        t_idle();
        t_fill();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule